// File: doc/BRIEF.md
# Single-Wire Sensor Bus Host with Pattern-Serialized Slots

This block is the host side of a single-wire, open-drain sensor bus. It does not time the bus with per-slot microsecond counters. Instead, every time slot is an 8-bit drive pattern. The pattern is shifted onto the line most-significant bit first at one of two bit rates. A pattern bit of 0 pulls the line low for one bit period, and a pattern bit of 1 leaves it released. While a pattern is being driven, the line is read back once per bit period through a two-flop synchronizer. The eight samples form a received pattern, and each slot is decoded by comparing that pattern against known values.

A small command port accepts three operations while `busy` is low: bus reset with presence detection, write byte, and read byte. A bus reset uses the slow rate and sends 0x07. It retries until the sampled pattern reads 0x05 or a retry limit runs out. On success, all later byte slots use the fast rate. Byte operations run eight slots, least-significant bit first. A one-cycle `done` pulse marks the end of each operation; for a read, the byte on `rd_byte` is valid at that pulse. The pad is modelled as a pull-down enable (`line_pull`) plus a line readback input (`line_in`). The outside world forms the wired-AND.

Top module: `owire_pattern_host`

## Requirements
- R1: After reset, `busy`, `done`, `no_device`, `echo_err` and `line_pull` are 0 and `rd_byte` is 0x00. While idle, the line is released.
- R2: A command is taken only when `cmd_valid` is high and `busy` is low. The `cmd_op` encoding is 0 = bus reset, 1 = write `cmd_byte`, 2 = read. Op 3, and any command offered while busy, has no effect.
- R3: A slot drives its 8-bit pattern MSB first, one bit per bit period. A 0 bit asserts `line_pull` for the whole period and a 1 bit releases the line. The line is sampled through two flops near the middle of each bit period.
- R4: A bus reset first selects the slow bit period, CLK_HZ/RST_BAUD clocks, and sends pattern 0x07. It repeats that slot until the sampled pattern equals 0x05.
- R5: Only a reset whose sampled pattern equals 0x05 selects the fast bit period, CLK_HZ/DATA_BAUD clocks, for byte slots. Before that, byte slots run at the slow period.
- R6: If RETRY_MAX reset slots pass without a 0x05 pattern, `no_device` rises, `done` pulses and the block goes idle. The next reset command clears `no_device`.
- R7: A write sends bit 0 of the byte first. A 0 bit uses pattern 0x01 (low for seven bit periods) and a 1 bit uses 0x7F (low for one bit period).
- R8: At the end of a write, `echo_err` is 1 if any slot's sampled pattern differed from the pattern sent, and 0 otherwise. It is cleared when the next write starts.
- R9: A read sends pattern 0x7F in each of eight slots. A bit reads 1 only if its sampled pattern is exactly 0x7F (for example, 0x0F reads 0). Bits are assembled least-significant bit first into `rd_byte`.
- R10: `done` is high for exactly one cycle at the end of each operation, and `busy` is already low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 reset, 1 write, 2 read, 3 ignored |
| cmd_byte | input | 8 | Byte to write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_byte | output | 8 | Byte assembled by the last read |
| no_device | output | 1 | Last reset saw no presence pattern |
| echo_err | output | 1 | Last write read back a pattern other than the one it sent |
| line_pull | output | 1 | Open-drain pull-down enable |
| line_in | input | 1 | Line level read back from the pad |

## Verification
The bench builds the block with CLK_HZ = 12 MHz, RST_BAUD = 1 MHz, DATA_BAUD = 2 MHz and RETRY_MAX = 4. This gives 12-clock and 6-clock bit periods, so a full byte takes under 400 cycles. That makes it possible to write all 256 byte values, each decoded from the measured low-pulse widths on the line, and to read 66 varied values from a modelled device. The short retry limit makes both the exhausted-retry path and a presence seen on the third attempt cheap to reach. The slow-versus-fast rate switch is then checked by pulse width before and after presence.

// File: rtl/owire_pattern_host.sv
module owire_pattern_host #(
  parameter int CLK_HZ    = 100_000_000,
  parameter int RST_BAUD  = 100_500,
  parameter int DATA_BAUD = 500_000,
  parameter int RETRY_MAX = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic [7:0] cmd_byte,
  output logic       busy,
  output logic       done,
  output logic [7:0] rd_byte,
  output logic       no_device,
  output logic       echo_err,
  output logic       line_pull,
  input  logic       line_in
);

  localparam int DIV_R = CLK_HZ / RST_BAUD;
  localparam int DIV_D = CLK_HZ / DATA_BAUD;
  localparam int CW    = $clog2(DIV_R + 1);
  localparam int TW    = $clog2(RETRY_MAX + 1);
  localparam logic [CW-1:0] END_R = CW'(DIV_R - 1);
  localparam logic [CW-1:0] END_D = CW'(DIV_D - 1);
  localparam logic [CW-1:0] SMP_R = CW'(DIV_R / 2 + 1);
  localparam logic [CW-1:0] SMP_D = CW'(DIV_D / 2 + 1);
  localparam logic [TW-1:0] LAST_TRY = TW'(RETRY_MAX - 1);
  localparam logic [1:0] OP_RST = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;
  localparam logic [7:0] P_RST = 8'h07, P_PRES = 8'h05, P_ZERO = 8'h01, P_ONE = 8'h7F;

  logic          run_q, fast_q, done_q, nodev_q, err_q, s1_q, s2_q;
  logic [1:0]    op_q;
  logic [7:0]    data_q, pat_q, rx_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    bit_q, slot_q;
  logic [TW-1:0] tries_q;

  function automatic logic [7:0] slot_pat(input logic [1:0] op, input logic b);
    if (op == OP_RST) return P_RST;
    if (op == OP_WR && !b) return P_ZERO;
    return P_ONE;
  endfunction

  wire [CW-1:0] end_cnt = fast_q ? END_D : END_R;
  wire [CW-1:0] smp_cnt = fast_q ? SMP_D : SMP_R;
  wire          acc      = cmd_valid && !run_q && cmd_op != 2'd3;
  wire          at_smp   = run_q && cnt_q == smp_cnt;
  wire          bit_end  = run_q && cnt_q == end_cnt;
  wire          slot_end = bit_end && bit_q == 3'd7;
  wire [2:0]    nxt_slot = slot_q + 3'd1;

  assign busy      = run_q;
  assign done      = done_q;
  assign rd_byte   = rd_q;
  assign no_device = nodev_q;
  assign echo_err  = err_q;
  assign line_pull = run_q && !pat_q[3'd7 - bit_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0; fast_q <= 1'b0; done_q <= 1'b0; nodev_q <= 1'b0;
      err_q <= 1'b0; s1_q <= 1'b1; s2_q <= 1'b1; op_q <= OP_RST;
      data_q <= '0; pat_q <= '0; rx_q <= '0; rd_q <= '0;
      cnt_q <= '0; bit_q <= '0; slot_q <= '0; tries_q <= '0;
    end else begin
      s1_q   <= line_in;
      s2_q   <= s1_q;
      done_q <= 1'b0;
      if (acc) begin
        run_q   <= 1'b1;
        op_q    <= cmd_op;
        data_q  <= cmd_byte;
        pat_q   <= slot_pat(cmd_op, cmd_byte[0]);
        cnt_q   <= '0;
        bit_q   <= '0;
        slot_q  <= '0;
        tries_q <= '0;
        if (cmd_op == OP_RST) begin
          fast_q  <= 1'b0;
          nodev_q <= 1'b0;
        end
        if (cmd_op == OP_WR) err_q <= 1'b0;
      end else if (run_q) begin
        if (at_smp) rx_q <= {rx_q[6:0], s2_q};
        if (bit_end) begin
          cnt_q <= '0;
          bit_q <= bit_q + 3'd1;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
        if (slot_end) begin
          case (op_q)
            OP_RST: begin
              if (rx_q == P_PRES) begin
                fast_q <= 1'b1;
                run_q  <= 1'b0;
                done_q <= 1'b1;
              end else if (tries_q == LAST_TRY) begin
                nodev_q <= 1'b1;
                run_q   <= 1'b0;
                done_q  <= 1'b1;
              end else begin
                tries_q <= tries_q + TW'(1);
              end
            end
            OP_WR: begin
              if (rx_q != pat_q) err_q <= 1'b1;
              slot_q <= nxt_slot;
              pat_q  <= slot_pat(OP_WR, data_q[nxt_slot]);
              if (slot_q == 3'd7) begin
                run_q  <= 1'b0;
                done_q <= 1'b1;
              end
            end
            default: begin
              rd_q   <= {rx_q == P_ONE, rd_q[7:1]};
              slot_q <= nxt_slot;
              if (slot_q == 3'd7) begin
                run_q  <= 1'b0;
                done_q <= 1'b1;
              end
            end
          endcase
        end
      end
    end
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy && cmd_op != 2'd3 |=> busy);
  assert_busy_holds_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_valid |=> $stable(op_q) && $stable(data_q));
  assert_bit_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cnt_q != '0 |-> $stable(line_pull));
  assert_rate_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fast_q) |-> done && !no_device);
  assert_nodev_on_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(no_device) |-> done && op_q == OP_RST);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: tb/sim_owire_pattern_host.sv
module sim_owire_pattern_host;
  localparam int DR = 12;
  localparam int DD = 6;
  localparam int TRIES = 4;
  localparam int WD_LIMIT = 195_000;

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_byte = 8'h00;
  logic busy, done, no_device, echo_err, line_pull;
  logic [7:0] rd_byte;
  logic dev_pull = 1'b0;
  wire  line = ~(line_pull | dev_pull);

  owire_pattern_host #(.CLK_HZ(12_000_000), .RST_BAUD(1_000_000),
                       .DATA_BAUD(2_000_000), .RETRY_MAX(TRIES)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_byte(cmd_byte), .busy(busy), .done(done), .rd_byte(rd_byte),
    .no_device(no_device), .echo_err(echo_err), .line_pull(line_pull),
    .line_in(line));

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  int runs [0:4095];
  int nruns = 0, run_len = 0, pull_rises = 0;
  logic prev_line = 1'b1, prev_pull = 1'b0;
  int dmode = 0, rbase = 0, rfall = 0, pres_base = 0, need = 0, resp_mark = -1;
  int fault_req = 0, fault_used = 0, dcnt = 0, pwait = 0;
  logic [7:0] rbits = 8'h00;

  always @(posedge clk) cycles <= cycles + 1;

  always @(negedge clk) begin
    logic lv, fell, rose;
    lv = line;
    fell = prev_line && !lv;
    rose = !prev_line && lv;
    if (line_pull && !prev_pull) pull_rises = pull_rises + 1;
    prev_pull = line_pull;
    if (!lv) run_len = run_len + 1;
    else if (!prev_line) begin
      runs[nruns % 4096] = run_len;
      nruns = nruns + 1;
      run_len = 0;
    end
    if (dcnt > 0) begin
      dcnt = dcnt - 1;
      if (dcnt == 0) dev_pull = 1'b0;
    end
    if (pwait > 0) begin
      pwait = pwait - 1;
      if (pwait == 0) begin dev_pull = 1'b1; dcnt = DR; end
    end
    case (dmode)
      1: if (fell) begin
           if (!rbits[(rfall - rbase) & 7]) begin dev_pull = 1'b1; dcnt = 4 * DD; end
           rfall = rfall + 1;
         end
      2: if (rose && !dev_pull && pull_rises - pres_base >= need && resp_mark != pull_rises) begin
           resp_mark = pull_rises;
           pwait = DR;
         end
      3: if (fell && fault_used != fault_req) begin
           fault_used = fault_req;
           dev_pull = 1'b1;
           dcnt = 4 * DD;
         end
      default: ;
    endcase
    prev_line = lv;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [7:0] b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_byte = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(!done && !busy, "R10 done one cycle", int'(done), 0);
  endtask

  task automatic write_decode(input logic [7:0] v, output logic [7:0] got, output bit shape_ok);
    int b;
    b = nruns;
    issue(2'd1, v);
    wait_done();
    shape_ok = (nruns - b) == 8;
    got = 8'h00;
    for (int k = 0; k < 8; k++) begin
      int r;
      r = runs[(b + k) % 4096];
      if (r == DD) got[k] = 1'b1;
      else if (r != 7 * DD) shape_ok = 0;
    end
  endtask

  initial begin
    logic [7:0] got;
    bit shp;
    int b, pr;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !no_device && !echo_err && !line_pull && rd_byte == 8'h00,
        "R1 reset state", int'({busy, done, no_device, echo_err, line_pull}), 0);

    issue(2'd3, 8'h55);
    pr = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (busy || line_pull) pr = pr + 1;
    end
    chk(pr == 0, "R2 op 3 ignored", pr, 0);

    b = nruns;
    issue(2'd1, 8'h00);
    wait_done();
    chk(runs[b % 4096] == 7 * DR, "R5 slow slots before presence", runs[b % 4096], 7 * DR);

    dmode = 2; need = 3; pres_base = pull_rises; b = nruns;
    issue(2'd0, 8'h00);
    wait_done();
    chk(!no_device, "R4 presence found", int'(no_device), 0);
    chk(pull_rises - pres_base == 3, "R4 reset retried until 0x05", pull_rises - pres_base, 3);
    chk(runs[b % 4096] == 5 * DR, "R4 reset pattern 0x07 at slow rate", runs[b % 4096], 5 * DR);
    dmode = 0;

    b = nruns;
    issue(2'd1, 8'h00);
    wait_done();
    chk(runs[b % 4096] == 7 * DD, "R5 fast slots after presence", runs[b % 4096], 7 * DD);

    for (int v = 0; v < 256; v++) begin
      write_decode(8'(v), got, shp);
      chk(shp && got == 8'(v), "R7 write slot patterns", int'(got), v);
      chk(!echo_err, "R8 clean write echo", int'(echo_err), 0);
    end

    b = nruns;
    issue(2'd1, 8'hCC);
    repeat (100) @(negedge clk);
    issue(2'd0, 8'h00);
    issue(2'd2, 8'h00);
    wait_done();
    pr = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (busy) pr = pr + 1;
    end
    chk(pr == 0 && nruns - b == 8, "R2 commands while busy ignored", pr, 0);

    fault_req = fault_req + 1; dmode = 3;
    issue(2'd1, 8'hFF);
    wait_done();
    chk(echo_err, "R8 echo mismatch flagged", int'(echo_err), 1);
    dmode = 0;
    write_decode(8'hBE, got, shp);
    chk(!echo_err && got == 8'hBE, "R8 flag cleared by next write", int'(echo_err), 0);

    dmode = 1;
    for (int i = 0; i < 66; i++) begin
      logic [7:0] v;
      v = (i == 64) ? 8'h00 : (i == 65) ? 8'hFF : 8'((i * 37 + 11) & 255);
      rbits = v; rbase = rfall;
      issue(2'd2, 8'h00);
      wait_done();
      chk(rd_byte == v, "R9 read byte", int'(rd_byte), int'(v));
    end
    dmode = 0;

    dmode = 2; need = 1000; pres_base = pull_rises;
    issue(2'd0, 8'h00);
    wait_done();
    chk(no_device, "R6 no device flagged", int'(no_device), 1);
    chk(pull_rises - pres_base == TRIES, "R6 retry limit", pull_rises - pres_base, TRIES);
    need = 1; pres_base = pull_rises;
    issue(2'd0, 8'h00);
    wait_done();
    chk(!no_device, "R6 flag cleared by next reset", int'(no_device), 0);
    dmode = 0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles >= WD_LIMIT);
    checks = checks + 1;
    errors = errors + 1;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, WD_LIMIT);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule